// File: doc/BRIEF.md
# Time-Shared Second-Order-Section IIR Filter

This block is a sixth-order recursive low-pass (or any other second-order-section cascade) built around one direct-form-II biquad datapath that is reused for each section in turn. A sample accepted on the input is passed through section 0, then section 1, then section 2, one section per clock. The two delay words of every section, and the value entering and leaving each biquad pass, are held in a small on-block memory. Every narrowing of a wide product sum uses round-half-to-even, and every result that leaves the 25-bit internal range is clipped. A power-of-two attenuation with its own rounding and 16-bit clipping sits after the last section.

Coefficients and the output shift are loaded through a simple write port while the engine is idle. Samples and coefficients are two's-complement fixed point: samples are 16-bit values with 15 fraction bits, internal words are 25-bit values with 15 fraction bits, and coefficients are 17-bit values with 15 fraction bits (so 32768 means 1.0).

Top module: `iir_sos_engine`

## Requirements
- R1: After synchronous reset, in_ready is 1, out_valid is 0, out_sample is 0, and all section delay words, coefficients and the output shift are 0.
- R2: A sample is taken on a rising edge where in_valid and in_ready are both 1; in_ready is 0 on the following cycles until the result appears, and out_valid is 1 for exactly one cycle, starting after the third rising edge following the accepting edge, with in_ready back at 1 in that same cycle.
- R3: Section s computes w = x − a1·w1 − a2·w2 and y = b0·w + b1·w1 + b2·w2 with its own coefficients, where x is the incoming sample for s = 0 and the output of section s−1 otherwise; sections run in the order 0, 1, 2.
- R4: Each product sum (30 fraction bits) is reduced to 15 fraction bits by round-half-to-even: an exact half rounds to the even neighbour, for positive and negative values alike.
- R5: The w and y results of every section clip to the 25-bit range [−16777216, 16777215] instead of wrapping.
- R6: The output equals the last section's y arithmetically shifted right by the shift setting, rounded half-to-even and clipped to [−32768, 32767]; the shift setting is the written value clamped to 0..15 (negative values act as 0).
- R7: A coefficient write is taken only on an edge where in_ready is 1; writes made while a sample is in progress leave every coefficient and the shift unchanged.
- R8: After each section pass its delay words update as w2 ← old w1 and w1 ← new w, and they persist from one sample to the next.
- R9: Write index selects the target: 0 = b0, 1 = b1, 2 = b2, 3 = a1, 4 = a2 of the section given by coef_sec, 5 = the output shift (coef_sec ignored).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_sample | input | 16 | Signed input sample, 15 fraction bits |
| in_ready | output | 1 | Engine idle, next sample may be taken |
| out_valid | output | 1 | One-cycle pulse, out_sample holds a new result |
| out_sample | output | 16 | Signed filtered sample, held until the next result |
| coef_we | input | 1 | Coefficient or shift write strobe |
| coef_sec | input | 2 | Section addressed by the write |
| coef_idx | input | 3 | Coefficient selector, see R9 |
| coef_data | input | 17 | Signed write value, 15 fraction bits for coefficients |

## Verification
A wrong delay word shows up only through feedback, so the bench drives an impulse through a resonant cascade and compares every output of a twelve-sample response with an independent model; a corrupted w1 or w2 distorts the very next result and keeps distorting later ones. Errors in rounding appear in the last bit of a single output, which the vector table targets with exact halves of both signs. A delay word that wraps instead of clipping flips the sign of the output within a sample or two of the divergent feedback reaching full scale. A write that slips through while busy changes the result of the next sample, which the bench inspects directly.

// File: rtl/iir_sos_pkg.sv
package iir_sos_pkg;

    localparam int SAMPLE_W = 16;
    localparam int STATE_W  = 25;
    localparam int FRAC_W   = 15;
    localparam int COEF_W   = 17;
    localparam int SHIFT_W  = 4;
    localparam int IDX_W    = 3;
    localparam int ACC_W    = STATE_W + COEF_W + 3;

    localparam logic [IDX_W-1:0] SEL_B0    = 3'd0;
    localparam logic [IDX_W-1:0] SEL_B1    = 3'd1;
    localparam logic [IDX_W-1:0] SEL_B2    = 3'd2;
    localparam logic [IDX_W-1:0] SEL_A1    = 3'd3;
    localparam logic [IDX_W-1:0] SEL_A2    = 3'd4;
    localparam logic [IDX_W-1:0] SEL_SHIFT = 3'd5;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [STATE_W-1:0]  state_word_t;
    typedef logic signed [COEF_W-1:0]   coef_word_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    typedef struct packed {
        coef_word_t b0;
        coef_word_t b1;
        coef_word_t b2;
        coef_word_t a1;
        coef_word_t a2;
    } coef_set_t;

    typedef struct packed {
        state_word_t w1;
        state_word_t w2;
    } delay_pair_t;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

    localparam acc_t STATE_HI  = acc_t'((64'sd1 <<< (STATE_W - 1)) - 64'sd1);
    localparam acc_t STATE_LO  = -STATE_HI - acc_t'(1);
    localparam acc_t SAMPLE_HI = acc_t'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
    localparam acc_t SAMPLE_LO = -SAMPLE_HI - acc_t'(1);
    localparam int   SHIFT_MAX = (1 << SHIFT_W) - 1;

    // Drop sh low bits, ties go to the even neighbour.
    function automatic acc_t round_even(input acc_t v, input int unsigned sh);
        acc_t q;
        acc_t r;
        acc_t half;
        if (sh == 0) return v;
        q    = v >>> sh;
        r    = v - (q <<< sh);
        half = acc_t'(1) <<< (sh - 1);
        if ((r > half) || ((r == half) && q[0])) q = q + acc_t'(1);
        return q;
    endfunction

    function automatic state_word_t clip_state(input acc_t v);
        if (v > STATE_HI) return state_word_t'(STATE_HI);
        if (v < STATE_LO) return state_word_t'(STATE_LO);
        return state_word_t'(v);
    endfunction

    function automatic sample_t clip_sample(input acc_t v);
        if (v > SAMPLE_HI) return sample_t'(SAMPLE_HI);
        if (v < SAMPLE_LO) return sample_t'(SAMPLE_LO);
        return sample_t'(v);
    endfunction

endpackage

// File: rtl/iir_coef_bank.sv
module iir_coef_bank
    import iir_sos_pkg::*;
#(
    parameter int N_SEC = 3,
    parameter int SEC_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             busy,
    input  logic [SEC_W-1:0] wr_sec,
    input  logic [IDX_W-1:0] wr_idx,
    input  coef_word_t       wr_data,
    input  logic [SEC_W-1:0] rd_sec,
    output coef_set_t        rd_set,
    output coef_word_t       shift_word
);

    coef_set_t [N_SEC-1:0] bank_q;
    coef_word_t            shift_q;
    logic                  wr_ok;

    assign wr_ok = wr_en && !busy;

    for (genvar g = 0; g < N_SEC; g++) begin : g_sec
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[g] <= '0;
            end else if (wr_ok && (wr_sec == SEC_W'(g))) begin
                case (wr_idx)
                    SEL_B0:  bank_q[g].b0 <= wr_data;
                    SEL_B1:  bank_q[g].b1 <= wr_data;
                    SEL_B2:  bank_q[g].b2 <= wr_data;
                    SEL_A1:  bank_q[g].a1 <= wr_data;
                    SEL_A2:  bank_q[g].a2 <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                               shift_q <= '0;
        else if (wr_ok && wr_idx == SEL_SHIFT) shift_q <= wr_data;
    end

    assign rd_set     = bank_q[rd_sec];
    assign shift_word = shift_q;

    // R7: nothing in the bank moves while a sample is in flight
    p_coef_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(bank_q) && $stable(shift_q)));

endmodule

// File: rtl/iir_state_mem.sv
module iir_state_mem
    import iir_sos_pkg::*;
#(
    parameter int N_SEC = 3,
    parameter int SEC_W = 2,
    parameter int IO_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  state_word_t      load_word,
    input  logic             pass_en,
    input  logic [SEC_W-1:0] sec,
    input  delay_pair_t      pass_pair,
    input  state_word_t      pass_out,
    output delay_pair_t      rd_pair,
    output state_word_t      rd_in
);

    delay_pair_t [N_SEC-1:0] delay_q;
    state_word_t [N_SEC:0]   io_q;
    logic [IO_W-1:0]         rd_slot;
    logic [IO_W-1:0]         wr_slot;

    assign rd_slot = IO_W'(sec);
    assign wr_slot = IO_W'(sec) + IO_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            delay_q <= '0;
            io_q    <= '0;
        end else begin
            if (load_en) io_q[0] <= load_word;
            if (pass_en) begin
                delay_q[sec]  <= pass_pair;
                io_q[wr_slot] <= pass_out;
            end
        end
    end

    assign rd_pair = delay_q[sec];
    assign rd_in   = io_q[rd_slot];

    // R8: the word written as w2 is the w1 that was stored before the pass
    p_delay_shift_r8: assert property (@(posedge clk) disable iff (rst)
        pass_en |-> (pass_pair.w2 == rd_pair.w1));

endmodule

// File: rtl/iir_biquad_core.sv
module iir_biquad_core
    import iir_sos_pkg::*;
(
    input  state_word_t x_in,
    input  coef_set_t   c,
    input  delay_pair_t d,
    output state_word_t w_out,
    output state_word_t y_out
);

    acc_t xe;
    acc_t w1e;
    acc_t w2e;
    acc_t we;
    acc_t acc_fb;
    acc_t acc_ff;

    assign xe  = acc_t'(x_in);
    assign w1e = acc_t'(d.w1);
    assign w2e = acc_t'(d.w2);

    // Recursive half: new state word
    assign acc_fb = (xe <<< FRAC_W) - acc_t'(c.a1) * w1e - acc_t'(c.a2) * w2e;
    assign w_out  = clip_state(round_even(acc_fb, FRAC_W));

    // Feed-forward half: section output
    assign we     = acc_t'(w_out);
    assign acc_ff = acc_t'(c.b0) * we + acc_t'(c.b1) * w1e + acc_t'(c.b2) * w2e;
    assign y_out  = clip_state(round_even(acc_ff, FRAC_W));

endmodule

// File: rtl/iir_out_scale.sv
module iir_out_scale
    import iir_sos_pkg::*;
(
    input  state_word_t y_in,
    input  coef_word_t  shift_word,
    output sample_t     y_out
);

    int unsigned sh;

    always_comb begin
        if (shift_word < 0)                       sh = 0;
        else if (shift_word > coef_word_t'(SHIFT_MAX)) sh = SHIFT_MAX;
        else                                      sh = int'(shift_word);
    end

    assign y_out = clip_sample(round_even(acc_t'(y_in), sh));

endmodule

// File: rtl/iir_sos_engine.sv
module iir_sos_engine
    import iir_sos_pkg::*;
#(
    parameter  int N_SECTIONS = 3,
    localparam int SEC_W      = (N_SECTIONS > 1) ? $clog2(N_SECTIONS) : 1,
    localparam int IO_W       = $clog2(N_SECTIONS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       in_ready,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_sample,
    input  logic                       coef_we,
    input  logic [SEC_W-1:0]           coef_sec,
    input  logic [IDX_W-1:0]           coef_idx,
    input  logic signed [COEF_W-1:0]   coef_data
);

    localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(N_SECTIONS - 1);

    seq_state_t       seq_q;
    logic [SEC_W-1:0] sec_q;
    logic             out_valid_q;
    sample_t          out_q;

    coef_set_t   cur_coef;
    coef_word_t  shift_word;
    delay_pair_t cur_pair;
    delay_pair_t next_pair;
    state_word_t cur_in;
    state_word_t w_new;
    state_word_t y_new;
    sample_t     scaled;
    logic        accept;
    logic        running;

    assign in_ready = (seq_q == SEQ_IDLE);
    assign running  = (seq_q == SEQ_RUN);
    assign accept   = in_valid && in_ready;

    iir_coef_bank #(.N_SEC(N_SECTIONS), .SEC_W(SEC_W)) coef_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (coef_we),
        .busy       (running),
        .wr_sec     (coef_sec),
        .wr_idx     (coef_idx),
        .wr_data    (coef_data),
        .rd_sec     (sec_q),
        .rd_set     (cur_coef),
        .shift_word (shift_word)
    );

    iir_state_mem #(.N_SEC(N_SECTIONS), .SEC_W(SEC_W), .IO_W(IO_W)) mem_i (
        .clk       (clk),
        .rst       (rst),
        .load_en   (accept),
        .load_word (state_word_t'(in_sample)),
        .pass_en   (running),
        .sec       (sec_q),
        .pass_pair (next_pair),
        .pass_out  (y_new),
        .rd_pair   (cur_pair),
        .rd_in     (cur_in)
    );

    iir_biquad_core core_i (
        .x_in  (cur_in),
        .c     (cur_coef),
        .d     (cur_pair),
        .w_out (w_new),
        .y_out (y_new)
    );

    iir_out_scale scale_i (
        .y_in       (y_new),
        .shift_word (shift_word),
        .y_out      (scaled)
    );

    assign next_pair.w1 = w_new;
    assign next_pair.w2 = cur_pair.w1;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q       <= SEQ_IDLE;
            sec_q       <= '0;
            out_valid_q <= 1'b0;
            out_q       <= '0;
        end else begin
            out_valid_q <= 1'b0;
            case (seq_q)
                SEQ_IDLE: begin
                    if (in_valid) begin
                        seq_q <= SEQ_RUN;
                        sec_q <= '0;
                    end
                end
                default: begin
                    if (sec_q == LAST_SEC) begin
                        seq_q       <= SEQ_IDLE;
                        out_valid_q <= 1'b1;
                        out_q       <= scaled;
                    end else begin
                        sec_q <= sec_q + SEC_W'(1);
                    end
                end
            endcase
        end
    end

    assign out_valid  = out_valid_q;
    assign out_sample = out_q;

    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_valid_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    // R3: sections are visited in ascending order, one per cycle
    p_sec_order_r3: assert property (@(posedge clk) disable iff (rst)
        (running && sec_q != LAST_SEC) |=> (running && sec_q == SEC_W'($past(sec_q) + 1'b1)));

endmodule

// File: tb/iir_sos_engine_tb_top.sv
module iir_sos_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_sample;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_sample;
    logic        coef_we;
    logic [1:0]  coef_sec;
    logic [2:0]  coef_idx;
    logic [16:0] coef_data;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    iir_sos_engine dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .coef_we    (coef_we),
        .coef_sec   (coef_sec),
        .coef_idx   (coef_idx),
        .coef_data  (coef_data)
    );

    // {input, shift, expected output}, identity sections
    localparam int NVEC = 12;
    localparam int VEC [NVEC][3] = '{
        '{100, 1, 50},  '{3, 1, 2},   '{5, 1, 2},   '{-3, 1, -2},
        '{-5, 1, -2},   '{7, 2, 2},   '{6, 2, 2},   '{10, 2, 2},
        '{32767, 0, 32767}, '{-32768, 0, -32768},
        '{-32768, 15, -1},  '{32767, 15, 1}
    };

    // Independent reference model
    longint mb [3][5];
    longint mw1 [3];
    longint mw2 [3];
    int     msh;

    function automatic longint m_round(longint v, int sh);
        longint q, r, h;
        if (sh == 0) return v;
        q = v >>> sh;
        r = v - (q <<< sh);
        h = longint'(1) <<< (sh - 1);
        if (r > h || (r == h && q[0])) q = q + 1;
        return q;
    endfunction

    function automatic longint m_clip(longint v, int bits);
        longint hi, lo;
        hi = (longint'(1) <<< (bits - 1)) - 1;
        lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint m_step(longint x);
        longint xs, aw, w, ay, y;
        xs = x;
        for (int s = 0; s < 3; s++) begin
            aw = (xs <<< 15) - mb[s][3] * mw1[s] - mb[s][4] * mw2[s];
            w  = m_clip(m_round(aw, 15), 25);
            ay = mb[s][0] * w + mb[s][1] * mw1[s] + mb[s][2] * mw2[s];
            y  = m_clip(m_round(ay, 15), 25);
            mw2[s] = mw1[s];
            mw1[s] = w;
            xs = y;
        end
        return m_clip(m_round(xs, msh), 16);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0; in_sample = '0;
        coef_we = 1'b0; coef_sec = '0; coef_idx = '0; coef_data = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < 3; s++) begin
            mw1[s] = 0; mw2[s] = 0;
            for (int k = 0; k < 5; k++) mb[s][k] = 0;
        end
        msh = 0;
    endtask

    task automatic wr(input int s, input int idx, input int d);
        @(negedge clk);
        coef_we = 1'b1; coef_sec = 2'(s); coef_idx = 3'(idx); coef_data = 17'(d);
        @(negedge clk);
        coef_we = 1'b0;
        if (idx < 5) mb[s][idx] = d;
        else msh = (d < 0) ? 0 : ((d > 15) ? 15 : d);
    endtask

    task automatic set_identity();
        for (int s = 0; s < 3; s++) begin
            wr(s, 0, 32768); wr(s, 1, 0); wr(s, 2, 0); wr(s, 3, 0); wr(s, 4, 0);
        end
    endtask

    // Sends one sample; optionally attempts a write while busy.
    task automatic send(input int x, input bit busy_wr, input int bw_idx,
                        input int bw_data, output int got);
        int n;
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'(x);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 in_ready low after take", longint'(in_ready), 0);
        if (busy_wr) begin
            coef_we = 1'b1; coef_sec = 2'd0; coef_idx = 3'(bw_idx); coef_data = 17'(bw_data);
        end
        n = 1;
        while (!out_valid && n < 20) begin
            @(negedge clk);
            coef_we = 1'b0;
            n++;
        end
        chk("R2 latency", n, 4);
        chk("R2 ready with result", longint'(in_ready), 1);
        got = int'($signed(out_sample));
        @(negedge clk);
        chk("R2 single pulse", longint'(out_valid), 0);
    endtask

    initial begin
        #(10 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int got;
        longint exp;
        do_reset();

        // R1 reset values
        @(negedge clk);
        chk("R1 in_ready", longint'(in_ready), 1);
        chk("R1 out_valid", longint'(out_valid), 0);
        chk("R1 out_sample", longint'($signed(out_sample)), 0);
        // R1: zero coefficients give zero output
        send(12345, 1'b0, 0, 0, got);
        chk("R1 zero coefficients", got, 0);

        // R4 R6 R9: vector table with identity sections
        set_identity();
        for (int v = 0; v < NVEC; v++) begin
            wr(0, 5, VEC[v][1]);
            send(VEC[v][0], 1'b0, 0, 0, got);
            void'(m_step(VEC[v][0]));
            chk($sformatf("R4 R6 vector %0d", v), got, VEC[v][2]);
        end

        // R6 shift clamp: 40 acts as 15, negative acts as 0
        wr(0, 5, 40);
        send(32767, 1'b0, 0, 0, got);
        chk("R6 shift clamp high", got, 1);
        wr(0, 5, -3);
        send(-1234, 1'b0, 0, 0, got);
        chk("R6 shift clamp negative", got, -1234);

        // R6 output clipping: gain near 2 per section
        wr(0, 5, 0);
        wr(0, 0, 65535); wr(1, 0, 65535); wr(2, 0, 65535);
        send(30000, 1'b0, 0, 0, got);
        chk("R6 clip high", got, 32767);
        send(-30000, 1'b0, 0, 0, got);
        chk("R6 clip low", got, -32768);

        // R3 R8: resonant cascade impulse response against the model
        do_reset();
        wr(0, 0, 8192); wr(0, 1, 16384); wr(0, 2, 8192); wr(0, 3, -52000); wr(0, 4, 24000);
        wr(1, 0, 12000); wr(1, 1, 20000); wr(1, 2, -6000); wr(1, 3, -30000); wr(1, 4, 9000);
        wr(2, 0, 40000); wr(2, 1, -9000); wr(2, 2, 3000); wr(2, 3, 10000); wr(2, 4, -5000);
        wr(0, 5, 0);
        for (int k = 0; k < 12; k++) begin
            send((k == 0) ? 10000 : 0, 1'b0, 0, 0, got);
            exp = m_step((k == 0) ? 10000 : 0);
            chk($sformatf("R3 R8 impulse sample %0d", k), got, exp);
        end

        // R5: divergent feedback clips the state at the top of the range
        do_reset();
        set_identity();
        wr(0, 3, -65535);
        wr(0, 5, 10);
        for (int k = 0; k < 12; k++) begin
            send(20000, 1'b0, 0, 0, got);
            exp = m_step(20000);
            chk($sformatf("R5 growth sample %0d", k), got, exp);
        end
        chk("R5 clipped value", got, 16384);

        // R7: writes during a run have no effect
        do_reset();
        set_identity();
        send(1000, 1'b1, 0, 0, got);
        void'(m_step(1000));
        chk("R7 run with busy write", got, 1000);
        send(1234, 1'b0, 0, 0, got);
        chk("R7 b0 unchanged", got, 1234);
        send(800, 1'b1, 5, 4, got);
        send(800, 1'b0, 0, 0, got);
        chk("R7 shift unchanged", got, 800);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule